// File: doc/BRIEF.md
# Dual-Mode Serial Command Receiver

This block is the receive-only serial front end of a display controller. An external host drives a serial clock, a serial data line, an active-low chip select and, in one framing, a data/command pin. The block oversamples all of these with its own fast system clock, rebuilds each word and hands it to the command logic as a parallel byte with a flag telling data from command, marked by a one-cycle valid strobe.

A static strap input picks the framing. With the strap low, words are eight bits long and the separate data/command pin supplies the flag. With the strap high, that pin is ignored and each word is nine bits long: the leading bit is the flag and the remaining eight are the byte. Bits are taken on rising serial clock edges, most significant first, only while chip select is low. Releasing chip select throws away any partly received word, and words may follow each other without releasing it.

Top module: `serial_cmd_rx`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `rx_valid` is 0, `rx_byte` is 0x00 and `rx_is_data` is 0, and stay so until a word completes.
- R2: With `frame_sel` = 0, eight rising serial clock edges with `cs_n` low form one byte, the first bit taken becoming `rx_byte[7]` and the last `rx_byte[0]`.
- R3: With `frame_sel` = 0, `rx_is_data` equals the level of `dc_in` when the eighth bit is taken (1 = data, 0 = command).
- R4: With `frame_sel` = 1, a word is nine bits: the first becomes `rx_is_data` (1 = data, 0 = command) and the next eight form `rx_byte`, most significant first; `dc_in` has no effect on either output.
- R5: `rx_valid` is high for exactly one system clock cycle per completed word and never on two consecutive cycles.
- R6: Serial clock edges seen while `cs_n` is high take no bits and produce no word.
- R7: Raising `cs_n` in the middle of a word abandons it; the next word after `cs_n` falls again is assembled starting from its first bit.
- R8: Several words sent while `cs_n` stays low are each delivered in order, the bit count restarting after every completed word.
- R9: Bits are taken on rising serial clock edges only; a change of `sdata_in` while the serial clock is high does not alter the taken bit.
- R10: `rx_valid` rises between two and four system clock cycles after the serial clock edge that carries the last bit of a word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_sel | input | 1 | Static framing strap: 0 = 8-bit words with pin flag, 1 = 9-bit words with in-band flag |
| sclk_in | input | 1 | External serial clock, asynchronous to `clk` |
| sdata_in | input | 1 | External serial data |
| cs_n | input | 1 | External chip select, active low |
| dc_in | input | 1 | Data/command pin, used only when `frame_sel` = 0 |
| rx_byte | output | 8 | Last received byte |
| rx_is_data | output | 1 | Flag of the last received byte: 1 = data, 0 = command |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_byte` |

## Verification
The assertions rely on the serial clock staying at each level for at least two system clock cycles, so that two rising edges seen after the synchronizer are never closer than four cycles; the bench holds the serial clock low for three cycles and high for two. They also take `frame_sel` as static while a word is in flight, and the bench only changes it with chip select high. Both byte sweeps cover all 256 values in each framing with the flag alternating and, in the nine-bit framing, the data/command pin driven opposite to the in-band flag, while the data line is flipped during every high phase of the serial clock.

// File: rtl/serial_rx_pkg.sv
// Shared definitions for the serial command receiver.
// Assumes nothing beyond a standard 8-bit byte as the default width.
package serial_rx_pkg;
    localparam int unsigned DEF_BYTE_W     = 8;
    localparam int unsigned DEF_SYNC_DEPTH = 2;

    // Framing picked by the static strap.
    typedef enum logic {
        FRAME_PIN_FLAG   = 1'b0,  // word of BYTE_W bits, flag from the pin
        FRAME_INBAND_FLAG = 1'b1  // word of BYTE_W+1 bits, flag is the first bit
    } frame_mode_e;
endpackage

// File: rtl/rx_sync.sv
// Multi-bit, multi-stage synchronizer for asynchronous level inputs.
// Assumes each bit is independent; no bus coherency is provided.
// Each bit resets to its own value from RESET_VAL.
module rx_sync #(
    parameter int unsigned WIDTH     = 4,
    parameter int unsigned DEPTH     = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [DEPTH];

    genvar s;
    generate
        for (s = 0; s < DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Purpose: first capture of the asynchronous inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= RESET_VAL;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Purpose: further settling stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RESET_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[DEPTH-1];
endmodule

// File: rtl/rx_deframer.sv
// Bit assembler: detects rising serial clock edges on synchronized inputs,
// counts bits within a word and emits the byte with its data/command flag.
// Assumes the synchronized serial clock holds each level for at least two
// system clock cycles and that the framing mode is stable within a word.
module rx_deframer
    import serial_rx_pkg::*;
#(
    parameter int unsigned BYTE_W = DEF_BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  frame_mode_e       mode,
    input  logic              sclk_s,
    input  logic              sdata_s,
    input  logic              csn_s,
    input  logic              dc_s,
    output logic [BYTE_W-1:0] byte_o,
    output logic              is_data_o,
    output logic              valid_o
);
    localparam int unsigned CNT_W = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] LAST_PIN    = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] LAST_INBAND = CNT_W'(BYTE_W);

    logic              sclk_prev_q;
    logic              sclk_rise;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic [CNT_W-1:0]  last_idx;
    logic [BYTE_W-1:0] shift_q;
    logic              flag_q;
    logic              take_flag;
    logic              word_done;

    // Purpose: remember the previous synchronized serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev_q <= 1'b0;
        else        sclk_prev_q <= sclk_s;
    end

    assign sclk_rise = sclk_s & ~sclk_prev_q;
    assign last_idx  = (mode == FRAME_INBAND_FLAG) ? LAST_INBAND : LAST_PIN;
    assign take_flag = (mode == FRAME_INBAND_FLAG) && (bit_cnt_q == '0);
    assign word_done = !csn_s && sclk_rise && (bit_cnt_q == last_idx);

    // Purpose: bit counter, cleared by chip select release and word end.
    always_ff @(posedge clk) begin
        if (!rst_n)                 bit_cnt_q <= '0;
        else if (csn_s)             bit_cnt_q <= '0;
        else if (word_done)         bit_cnt_q <= '0;
        else if (sclk_rise)         bit_cnt_q <= bit_cnt_q + 1'b1;
    end

    // Purpose: shift register and in-band flag capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            flag_q  <= 1'b0;
        end else if (!csn_s && sclk_rise) begin
            if (take_flag) flag_q  <= sdata_s;
            else           shift_q <= {shift_q[BYTE_W-2:0], sdata_s};
        end
    end

    // Purpose: register the completed word and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_o    <= '0;
            is_data_o <= 1'b0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= word_done;
            if (word_done) begin
                byte_o    <= {shift_q[BYTE_W-2:0], sdata_s};
                is_data_o <= (mode == FRAME_INBAND_FLAG) ? flag_q : dc_s;
            end
        end
    end

    // R5: the strobe never lasts two cycles.
    p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R6: no word leaves while chip select is released.
    p_cs_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> !valid_o);

    // R7: chip select release leaves the counter at the first bit.
    p_cs_abandon_r7: assert property (@(posedge clk) disable iff (!rst_n)
        csn_s |=> (bit_cnt_q == '0));

    // R2: in pin-flag framing the count stays below the byte width.
    p_cnt_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FRAME_PIN_FLAG) |-> (bit_cnt_q <= LAST_PIN));

    // R4: in in-band framing the count never passes the ninth bit.
    p_cnt_inband_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt_q <= LAST_INBAND);

    // R9: a strobe follows only a rising serial clock seen with chip select low.
    p_valid_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(sclk_s) && !$past(sclk_prev_q) && !$past(csn_s)));
endmodule

// File: rtl/serial_cmd_rx.sv
// Top of the dual-mode serial command receiver. Synchronizes the serial
// pins into the system clock domain and feeds the bit assembler.
// Assumes clk runs at least four times the serial clock rate and that
// frame_sel is a static strap.
module serial_cmd_rx
    import serial_rx_pkg::*;
#(
    parameter int unsigned BYTE_W     = DEF_BYTE_W,
    parameter int unsigned SYNC_DEPTH = DEF_SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sel,
    input  logic              sclk_in,
    input  logic              sdata_in,
    input  logic              cs_n,
    input  logic              dc_in,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_is_data,
    output logic              rx_valid
);
    localparam int unsigned PIN_W = 4;
    // Bit order: {dc, cs_n, sdata, sclk}; chip select idles high.
    localparam logic [PIN_W-1:0] PIN_IDLE = 4'b0100;

    logic [PIN_W-1:0] pins_s;

    rx_sync #(
        .WIDTH     (PIN_W),
        .DEPTH     (SYNC_DEPTH),
        .RESET_VAL (PIN_IDLE)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({dc_in, cs_n, sdata_in, sclk_in}),
        .sync_out (pins_s)
    );

    rx_deframer #(
        .BYTE_W (BYTE_W)
    ) u_deframer (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (frame_mode_e'(frame_sel)),
        .sclk_s    (pins_s[0]),
        .sdata_s   (pins_s[1]),
        .csn_s     (pins_s[2]),
        .dc_s      (pins_s[3]),
        .byte_o    (rx_byte),
        .is_data_o (rx_is_data),
        .valid_o   (rx_valid)
    );
endmodule

// File: tb/serial_cmd_rx_test.sv
module serial_cmd_rx_test;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_WORDS  = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sel = 1'b0;
    logic       sclk_in = 1'b0;
    logic       sdata_in = 1'b0;
    logic       cs_n = 1'b1;
    logic       dc_in = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_is_data;
    logic       rx_valid;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_rise_cyc = 0;
    int rx_cnt = 0;
    logic [7:0] got_byte [MAX_WORDS];
    logic       got_flag [MAX_WORDS];
    logic       prev_valid = 1'b0;
    bit         done = 1'b0;

    serial_cmd_rx uut (
        .clk(clk), .rst_n(rst_n), .frame_sel(frame_sel),
        .sclk_in(sclk_in), .sdata_in(sdata_in), .cs_n(cs_n), .dc_in(dc_in),
        .rx_byte(rx_byte), .rx_is_data(rx_is_data), .rx_valid(rx_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: collect words, check strobe width (R5) and latency (R10).
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                check(!prev_valid, "R5 strobe on consecutive cycles", 1, 0);
                check((cyc - last_rise_cyc) >= 2 && (cyc - last_rise_cyc) <= 4,
                      "R10 strobe latency", cyc - last_rise_cyc, 3);
                if (rx_cnt < MAX_WORDS) begin
                    got_byte[rx_cnt] = rx_byte;
                    got_flag[rx_cnt] = rx_is_data;
                end
                rx_cnt++;
            end
            prev_valid = rx_valid;
        end
    end

    // One serial bit: low 3 cycles, high 2; data flipped while high (R9).
    task automatic send_bit(input logic b);
        @(negedge clk); sdata_in = b; sclk_in = 1'b0;
        repeat (2) @(negedge clk);
        sclk_in = 1'b1; last_rise_cyc = cyc;
        @(negedge clk); sdata_in = ~b;
        @(negedge clk); sclk_in = 1'b0;
    endtask

    task automatic send_pin_word(input logic [7:0] v, input logic dc);
        dc_in = dc;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_inband_word(input logic [7:0] v, input logic flag);
        dc_in = ~flag;  // pin driven opposite: must be ignored (R4)
        send_bit(flag);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic cs_low();
        @(negedge clk); cs_n = 1'b0; repeat (3) @(negedge clk);
    endtask

    task automatic cs_high();
        repeat (6) @(negedge clk); cs_n = 1'b1; repeat (4) @(negedge clk);
    endtask

    task automatic expect_word(input int idx, input logic [7:0] v, input logic f, input string tag);
        check(rx_cnt == idx + 1, {tag, " word count"}, rx_cnt, idx + 1);
        if (idx < MAX_WORDS) begin
            check(got_byte[idx] == v, {tag, " byte"}, int'(got_byte[idx]), int'(v));
            check(got_flag[idx] == f, {tag, " flag"}, int'(got_flag[idx]), int'(f));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(rx_valid == 1'b0, "R1 valid after reset", rx_valid, 0);
        check(rx_byte == 8'h00, "R1 byte after reset", rx_byte, 0);
        check(rx_is_data == 1'b0, "R1 flag after reset", rx_is_data, 0);
        check(rx_cnt == 0, "R1 no word after reset", rx_cnt, 0);

        // R2, R3, R9: all bytes in pin-flag framing, flag from dc_in
        frame_sel = 1'b0;
        for (int v = 0; v < 256; v++) begin
            cs_low();
            send_pin_word(8'(v), v[0] ^ v[3]);
            cs_high();
            expect_word(rx_cnt - 1 < 0 ? 0 : v, 8'(v), v[0] ^ v[3], "R2/R3 pin framing");
        end

        // R4, R9: all bytes in in-band framing, dc_in opposite to flag
        frame_sel = 1'b1;
        repeat (4) @(negedge clk);
        for (int v = 0; v < 256; v++) begin
            cs_low();
            send_inband_word(8'(v), ~v[1]);
            cs_high();
            expect_word(256 + v, 8'(v), ~v[1], "R4 in-band framing");
        end

        // R6: serial clock toggles with chip select high give no word
        base = rx_cnt;
        frame_sel = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < 20; i++) send_bit(i[0]);
        repeat (8) @(negedge clk);
        check(rx_cnt == base, "R6 edges with cs high", rx_cnt, base);

        // R7: partial word abandoned (pin framing)
        base = rx_cnt;
        cs_low();
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        cs_high();
        check(rx_cnt == base, "R7 partial pin word dropped", rx_cnt, base);
        cs_low();
        send_pin_word(8'h3C, 1'b0);
        cs_high();
        expect_word(base, 8'h3C, 1'b0, "R7 realign pin framing");

        // R7: partial word abandoned (in-band framing)
        frame_sel = 1'b1;
        repeat (4) @(negedge clk);
        base = rx_cnt;
        cs_low();
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        cs_high();
        check(rx_cnt == base, "R7 partial in-band word dropped", rx_cnt, base);
        cs_low();
        send_inband_word(8'h81, 1'b0);
        cs_high();
        expect_word(base, 8'h81, 1'b0, "R7 realign in-band framing");

        // R8: back-to-back words in both framings without releasing cs_n
        base = rx_cnt;
        cs_low();
        for (int k = 0; k < 6; k++) send_inband_word(8'(8'hA5 + 8'(k * 37)), k[0]);
        cs_high();
        for (int k = 0; k < 6; k++) begin
            check(got_byte[base + k] == 8'(8'hA5 + 8'(k * 37)), "R8 burst in-band byte",
                  int'(got_byte[base + k]), int'(8'(8'hA5 + 8'(k * 37))));
            check(got_flag[base + k] == k[0], "R8 burst in-band flag",
                  int'(got_flag[base + k]), int'(k[0]));
        end
        check(rx_cnt == base + 6, "R8 burst in-band count", rx_cnt, base + 6);

        frame_sel = 1'b0;
        repeat (4) @(negedge clk);
        base = rx_cnt;
        cs_low();
        for (int k = 0; k < 6; k++) send_pin_word(8'(8'h0F ^ 8'(k * 53)), ~k[0]);
        cs_high();
        for (int k = 0; k < 6; k++) begin
            check(got_byte[base + k] == 8'(8'h0F ^ 8'(k * 53)), "R8 burst pin byte",
                  int'(got_byte[base + k]), int'(8'(8'h0F ^ 8'(k * 53))));
            check(got_flag[base + k] == ~k[0], "R8 burst pin flag",
                  int'(got_flag[base + k]), int'(~k[0]));
        end
        check(rx_cnt == base + 6, "R8 burst pin count", rx_cnt, base + 6);

        repeat (10) @(negedge clk);
        check(rx_valid == 1'b0, "R5 strobe idle at end", rx_valid, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule